// File: doc/BRIEF.md
# Outstanding Line-Miss Tracker with Register Scoreboard

This block sits beside a non-blocking data cache in an in-order pipeline and keeps track of the cache lines that have missed and are still out in memory. Each tracking entry holds one line address. For every word of that line it records which destination register, if any, is waiting for that word. When a load misses, the block either opens a fresh entry and sends one memory request for the line, or folds the load into the entry that already covers that line, so no second request goes out. In both cases the load's destination register is marked empty and the load can leave the pipeline.

When memory returns a line, which arrives as a single beat tagged with the entry index, every waiting register gets its word on a parallel write-back port. Its empty mark is cleared at the same clock edge, and the entry becomes free. A small query port reports whether a register is still empty, so decode can hold back an instruction that reads it. The memory system and the register file are outside the block.

Top module: `miss_holding_file`

## Requirements
- R1: After reset no entry is in use, no memory request is presented, no write-back is active, and every register reads as full (q_empty = 0).
- R2: A load miss (ld_valid) to a line with no live entry is accepted when an entry is free. It takes the lowest-numbered free entry, and a request for that line is later presented with mreq_tag equal to that entry's index.
- R3: A load miss to a line that already has a live entry, on a word slot not yet claimed, is accepted and merged into that entry. It creates no additional memory request.
- R4: An accepted load marks its destination register empty from the next cycle on, and q_empty[k] reports that for the register named by q_reg[k*RW +: RW].
- R5: A load miss whose line has no live entry is refused (ld_accept = 0) while all entries are in use.
- R6: A load miss to a live line whose addressed word slot is already claimed is refused.
- R7: A load miss whose destination register is already empty is refused.
- R8: Requests are presented one at a time. While no request is being held, the lowest-numbered entry with an unsent request is presented. Once mreq_valid is shown without mreq_ready, the same tag and line stay presented until the handshake completes, and an entry's request is sent exactly once.
- R9: In the cycle fill_valid is high, wb_valid[w] is high exactly for the word slots claimed in entry fill_tag. wb_reg[w*RW +: RW] names the waiting register, and wb_data[w*DATA_W +: DATA_W] equals fill_data[w*DATA_W +: DATA_W].
- R10: After a refill every written-back register reads full again and the entry is free for a new line from the next cycle.
- R11: An entry being refilled in the current cycle does not accept a merge. A load to that line in that cycle is treated as a miss to an untracked line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load has missed this cycle |
| ld_line | input | LINE_AW | Line address of the missing load |
| ld_word | input | WW | Word slot within the line |
| ld_dest | input | RW | Destination register of the load |
| ld_accept | output | 1 | Load taken this cycle (otherwise stall) |
| mreq_valid | output | 1 | Memory request presented |
| mreq_ready | input | 1 | Memory takes the request |
| mreq_line | output | LINE_AW | Line address requested |
| mreq_tag | output | IW | Entry index returned with the refill |
| fill_valid | input | 1 | Refill beat present |
| fill_tag | input | IW | Entry the refill belongs to |
| fill_data | input | WORDS*DATA_W | Whole line, word w at bits w*DATA_W |
| wb_valid | output | WORDS | Per-word register write enable |
| wb_reg | output | WORDS*RW | Per-word destination register |
| wb_data | output | WORDS*DATA_W | Per-word write data |
| q_reg | input | NQ*RW | Registers queried by decode |
| q_empty | output | NQ | Queried register is still waiting |

## Verification
The accept decision, the presented request and the write-back port all depend on the inputs combinationally and are due in the same cycle as the stimulus. The empty marks, the entry contents and the freeing of an entry take effect at the next rising edge, so query results and later accept decisions reflect them one cycle after the stimulus. The bench drives each cycle's inputs just after the falling edge and samples outputs one nanosecond later, well clear of the rising edge. It updates its reference model only after those samples, so every comparison against model state describes the registered state before the coming edge.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   // Direction in which a priority picker scans its request vector.
   typedef enum logic {
      PICK_LOW  = 1'b0,
      PICK_HIGH = 1'b1
   } pick_dir_e;

   localparam int unsigned DEF_ENTRIES = 4;
   localparam int unsigned DEF_WORDS   = 8;
   localparam int unsigned DEF_REGS    = 32;
   localparam int unsigned DEF_LINE_AW = 26;
   localparam int unsigned DEF_DATA_W  = 32;
   localparam int unsigned DEF_QUERIES = 2;
endpackage

// File: rtl/mhf_pick.sv
module mhf_pick
   import mhf_pkg::*;
#(
   parameter int unsigned N   = 4,
   parameter int unsigned IW  = 2,
   parameter pick_dir_e   DIR = PICK_LOW
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   generate
      if (DIR == PICK_LOW) begin : g_low
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
      end else begin : g_high
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mhf_entry.sv
module mhf_entry #(
   parameter int unsigned LINE_AW = 26,
   parameter int unsigned WORDS   = 8,
   parameter int unsigned WW      = 3,
   parameter int unsigned RW      = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alloc_i,
   input  logic                       merge_i,
   input  logic                       take_i,
   input  logic                       fill_i,
   input  logic [LINE_AW-1:0]         ld_line,
   input  logic [WW-1:0]              ld_word,
   input  logic [RW-1:0]              ld_dest,
   output logic                       busy_o,
   output logic                       hit_o,
   output logic                       req_pend_o,
   output logic [LINE_AW-1:0]         line_o,
   output logic [WORDS-1:0]           used_o,
   output logic [WORDS-1:0][RW-1:0]   dest_o
);
   logic                     busy_q;
   logic                     pend_q;
   logic [LINE_AW-1:0]       line_q;
   logic [WORDS-1:0]         used_q;
   logic [WORDS-1:0][RW-1:0] dest_q;
   logic [WORDS-1:0]         word_sel;

   always_comb begin
      word_sel = '0;
      word_sel[ld_word] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= 1'b0;
         line_q <= '0;
         used_q <= '0;
         dest_q <= '0;
      end else begin
         if (fill_i) begin
            busy_q <= 1'b0;
            used_q <= '0;
         end else if (alloc_i) begin
            busy_q          <= 1'b1;
            line_q          <= ld_line;
            used_q          <= word_sel;
            dest_q[ld_word] <= ld_dest;
         end else if (merge_i) begin
            used_q          <= used_q | word_sel;
            dest_q[ld_word] <= ld_dest;
         end
         if (alloc_i)     pend_q <= 1'b1;
         else if (take_i) pend_q <= 1'b0;
      end
   end

   // A line in its refill cycle is about to vanish: it must not absorb a merge.
   assign hit_o      = busy_q && (line_q == ld_line) && !fill_i;
   assign busy_o     = busy_q;
   assign req_pend_o = pend_q;
   assign line_o     = line_q;
   assign used_o     = used_q;
   assign dest_o     = dest_q;
endmodule

// File: rtl/mhf_scoreboard.sv
module mhf_scoreboard #(
   parameter int unsigned NREGS = 32,
   parameter int unsigned RW    = 5,
   parameter int unsigned NQ    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [RW-1:0]     set_idx,
   input  logic [NREGS-1:0]  clr_mask,
   input  logic [NQ*RW-1:0]  q_idx,
   output logic [NQ-1:0]     q_empty,
   output logic [NREGS-1:0]  empty_o
);
   logic [NREGS-1:0] empty_q;
   logic [NREGS-1:0] set_mask;

   always_comb begin
      set_mask = '0;
      if (set_i) set_mask[set_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) empty_q <= '0;
      else        empty_q <= (empty_q & ~clr_mask) | set_mask;
   end

   generate
      for (genvar k = 0; k < NQ; k++) begin : g_query
         assign q_empty[k] = empty_q[q_idx[k*RW +: RW]];
      end
   endgenerate

   assign empty_o = empty_q;
endmodule

// File: rtl/miss_holding_file.sv
module miss_holding_file
   import mhf_pkg::*;
#(
   parameter int unsigned ENTRIES   = DEF_ENTRIES,
   parameter int unsigned WORDS     = DEF_WORDS,
   parameter int unsigned NREGS     = DEF_REGS,
   parameter int unsigned LINE_AW   = DEF_LINE_AW,
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned NQ        = DEF_QUERIES,
   parameter pick_dir_e   ALLOC_DIR = PICK_LOW,
   parameter pick_dir_e   REQ_DIR   = PICK_LOW,
   localparam int unsigned IW       = $clog2(ENTRIES),
   localparam int unsigned WW       = $clog2(WORDS),
   localparam int unsigned RW       = $clog2(NREGS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_valid,
   input  logic [LINE_AW-1:0]        ld_line,
   input  logic [WW-1:0]             ld_word,
   input  logic [RW-1:0]             ld_dest,
   output logic                      ld_accept,
   output logic                      mreq_valid,
   input  logic                      mreq_ready,
   output logic [LINE_AW-1:0]        mreq_line,
   output logic [IW-1:0]             mreq_tag,
   input  logic                      fill_valid,
   input  logic [IW-1:0]             fill_tag,
   input  logic [WORDS*DATA_W-1:0]   fill_data,
   output logic [WORDS-1:0]          wb_valid,
   output logic [WORDS*RW-1:0]       wb_reg,
   output logic [WORDS*DATA_W-1:0]   wb_data,
   input  logic [NQ*RW-1:0]          q_reg,
   output logic [NQ-1:0]             q_empty
);
   // Elaboration-time parameter checks.
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_regs
      $error("NREGS must be a power of two of at least 2");
   end
   if (NQ < 1 || LINE_AW < 1 || DATA_W < 1) begin : g_bad_width
      $error("NQ, LINE_AW and DATA_W must be nonzero");
   end

   logic [ENTRIES-1:0]        e_busy, e_hit, e_reqp;
   logic [ENTRIES-1:0]        e_alloc, e_merge, e_take, e_fill;
   logic [LINE_AW-1:0]        e_line [ENTRIES];
   logic [WORDS-1:0]          e_used [ENTRIES];
   logic [WORDS-1:0][RW-1:0]  e_dest [ENTRIES];

   logic          hit_any, free_any, pend_any;
   logic [IW-1:0] hit_idx, free_idx, pend_idx;
   logic          slot_taken, dest_wait;
   logic          do_alloc, do_merge;
   logic          hold_q;
   logic [IW-1:0] hold_idx_q;
   logic [NREGS-1:0] sb_empty, clr_mask;

   // ---------------- tracking entries ----------------
   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
         assign e_alloc[i] = do_alloc && (free_idx == IW'(i));
         assign e_merge[i] = do_merge && (hit_idx == IW'(i));
         assign e_take[i]  = mreq_valid && mreq_ready && (mreq_tag == IW'(i));
         assign e_fill[i]  = fill_valid && (fill_tag == IW'(i));

         mhf_entry #(
            .LINE_AW (LINE_AW),
            .WORDS   (WORDS),
            .WW      (WW),
            .RW      (RW)
         ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (e_alloc[i]),
            .merge_i    (e_merge[i]),
            .take_i     (e_take[i]),
            .fill_i     (e_fill[i]),
            .ld_line    (ld_line),
            .ld_word    (ld_word),
            .ld_dest    (ld_dest),
            .busy_o     (e_busy[i]),
            .hit_o      (e_hit[i]),
            .req_pend_o (e_reqp[i]),
            .line_o     (e_line[i]),
            .used_o     (e_used[i]),
            .dest_o     (e_dest[i])
         );
      end
   endgenerate

   // ---------------- selection ----------------
   mhf_pick #(.N(ENTRIES), .IW(IW), .DIR(PICK_LOW)) u_hit_pick (
      .req   (e_hit),
      .found (hit_any),
      .idx   (hit_idx)
   );

   mhf_pick #(.N(ENTRIES), .IW(IW), .DIR(ALLOC_DIR)) u_free_pick (
      .req   (~e_busy),
      .found (free_any),
      .idx   (free_idx)
   );

   mhf_pick #(.N(ENTRIES), .IW(IW), .DIR(REQ_DIR)) u_req_pick (
      .req   (e_reqp),
      .found (pend_any),
      .idx   (pend_idx)
   );

   // ---------------- load acceptance ----------------
   assign slot_taken = e_used[hit_idx][ld_word];
   assign dest_wait  = sb_empty[ld_dest];
   assign ld_accept  = ld_valid && !dest_wait &&
                       (hit_any ? !slot_taken : free_any);
   assign do_alloc   = ld_accept && !hit_any;
   assign do_merge   = ld_accept && hit_any;

   // ---------------- memory request port ----------------
   // A request shown without ready is frozen until taken.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= 1'b0;
         hold_idx_q <= '0;
      end else begin
         hold_q     <= mreq_valid && !mreq_ready;
         hold_idx_q <= mreq_tag;
      end
   end

   assign mreq_valid = hold_q || pend_any;
   assign mreq_tag   = hold_q ? hold_idx_q : pend_idx;
   assign mreq_line  = e_line[mreq_tag];

   // ---------------- refill write-back ----------------
   always_comb begin
      clr_mask = '0;
      for (int w = 0; w < WORDS; w++) begin
         wb_valid[w]          = fill_valid && e_used[fill_tag][w];
         wb_reg[w*RW +: RW]   = e_dest[fill_tag][w];
         if (wb_valid[w]) clr_mask[e_dest[fill_tag][w]] = 1'b1;
      end
   end

   assign wb_data = fill_data;

   // ---------------- register scoreboard ----------------
   mhf_scoreboard #(.NREGS(NREGS), .RW(RW), .NQ(NQ)) u_sb (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (ld_accept),
      .set_idx  (ld_dest),
      .clr_mask (clr_mask),
      .q_idx    (q_reg),
      .q_empty  (q_empty),
      .empty_o  (sb_empty)
   );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned NREGS   = 32,
   parameter int unsigned LINE_AW = 26,
   localparam int unsigned IW     = $clog2(ENTRIES),
   localparam int unsigned RW     = $clog2(NREGS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ld_valid,
   input logic [RW-1:0]       ld_dest,
   input logic                ld_accept,
   input logic                mreq_valid,
   input logic                mreq_ready,
   input logic [IW-1:0]       mreq_tag,
   input logic [LINE_AW-1:0]  mreq_line,
   input logic                fill_valid,
   input logic [IW-1:0]       fill_tag,
   input logic [ENTRIES-1:0]  e_busy,
   input logic [ENTRIES-1:0]  e_hit,
   input logic [ENTRIES-1:0]  e_reqp,
   input logic [NREGS-1:0]    sb_empty
);
   p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(e_hit) <= 1);

   p_dest_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_accept |=> sb_empty[$past(ld_dest)]);

   p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && (e_hit == '0) && (&e_busy)) |-> !ld_accept);

   p_wait_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && sb_empty[ld_dest]) |-> !ld_accept);

   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && !mreq_ready) |=>
         (mreq_valid && $stable(mreq_tag) && $stable(mreq_line)));

   p_fill_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (e_busy[fill_tag] && !e_reqp[fill_tag]));

   p_fill_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> !e_busy[$past(fill_tag)]);
endmodule

bind miss_holding_file mhf_checker #(
   .ENTRIES (ENTRIES),
   .NREGS   (NREGS),
   .LINE_AW (LINE_AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_valid   (ld_valid),
   .ld_dest    (ld_dest),
   .ld_accept  (ld_accept),
   .mreq_valid (mreq_valid),
   .mreq_ready (mreq_ready),
   .mreq_tag   (mreq_tag),
   .mreq_line  (mreq_line),
   .fill_valid (fill_valid),
   .fill_tag   (fill_tag),
   .e_busy     (e_busy),
   .e_hit      (e_hit),
   .e_reqp     (e_reqp),
   .sb_empty   (sb_empty)
);

// File: tb/miss_holding_file_test.sv
module miss_holding_file_test;
   localparam int NE = 4, NW = 8, NR = 32, LAW = 26, DW = 32, NQ = 2;
   localparam int IW = 2, WW = 3, RW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ld_valid = 1'b0;
   logic [LAW-1:0] ld_line = '0;
   logic [WW-1:0] ld_word = '0;
   logic [RW-1:0] ld_dest = '0;
   logic ld_accept, mreq_valid;
   logic mreq_ready = 1'b0;
   logic [LAW-1:0] mreq_line;
   logic [IW-1:0] mreq_tag;
   logic fill_valid = 1'b0;
   logic [IW-1:0] fill_tag = '0;
   logic [NW*DW-1:0] fill_data = '0;
   logic [NW-1:0] wb_valid;
   logic [NW*RW-1:0] wb_reg;
   logic [NW*DW-1:0] wb_data;
   logic [NQ*RW-1:0] q_reg = '0;
   logic [NQ-1:0] q_empty;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // reference model state
   bit            m_busy [NE];
   bit            m_reqp [NE];
   bit [LAW-1:0]  m_line [NE];
   bit            m_used [NE][NW];
   bit [RW-1:0]   m_dest [NE][NW];
   bit            m_empty [NR];
   bit            m_hold;
   bit [IW-1:0]   m_hold_idx;

   always #4 clk = ~clk;

   miss_holding_file uut (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_line(ld_line), .ld_word(ld_word), .ld_dest(ld_dest),
      .ld_accept(ld_accept),
      .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_line(mreq_line),
      .mreq_tag(mreq_tag),
      .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
      .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
      .q_reg(q_reg), .q_empty(q_empty)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int e = 0; e < NE; e++) if (!m_busy[e]) return e;
      return -1;
   endfunction

   function automatic int lowest_pend();
      for (int e = 0; e < NE; e++) if (m_reqp[e]) return e;
      return -1;
   endfunction

   // One cycle: drive after falling edge, sample 1 ns later, then advance model.
   task automatic cycle(input bit lv, input bit [LAW-1:0] ln, input int wd, input int ds,
                        input bit rdy, input bit fv, input int ft, input string qtag);
      int hit, fr, pe, etag;
      bit exp_acc, exp_mv;
      string why;
      ld_valid = lv; ld_line = ln; ld_word = WW'(wd); ld_dest = RW'(ds);
      mreq_ready = rdy; fill_valid = fv; fill_tag = IW'(ft);
      for (int w = 0; w < NW; w++) fill_data[w*DW +: DW] = $urandom;
      for (int k = 0; k < NQ; k++) q_reg[k*RW +: RW] = RW'($urandom_range(NR - 1));
      #1;
      // expected accept
      hit = -1;
      for (int e = 0; e < NE; e++)
         if (m_busy[e] && m_line[e] == ln && !(fv && ft == e)) hit = e;
      fr = lowest_free();
      if (m_empty[ds]) begin exp_acc = 0; why = "R7 dest waiting"; end
      else if (hit >= 0) begin
         exp_acc = !m_used[hit][wd];
         why = exp_acc ? "R3 merge" : "R6 slot claimed";
      end else begin
         exp_acc = (fr >= 0);
         why = exp_acc ? "R2 allocate" : "R5 no free entry";
         if (fv && m_busy[ft] && m_line[ft] == ln) why = "R11 refill line";
      end
      exp_acc = exp_acc && lv;
      if (lv) chk(ld_accept == exp_acc, why, "ld_accept", ld_accept, exp_acc);
      else    chk(ld_accept == 1'b0, "R2", "ld_accept idle", ld_accept, 0);
      // expected request
      pe = lowest_pend();
      exp_mv = m_hold || (pe >= 0);
      etag = m_hold ? int'(m_hold_idx) : pe;
      chk(mreq_valid == exp_mv, "R8", "mreq_valid", mreq_valid, exp_mv);
      if (exp_mv) begin
         chk(mreq_tag == IW'(etag), "R8", "mreq_tag", mreq_tag, etag);
         chk(mreq_line == m_line[etag], "R2", "mreq_line", mreq_line, m_line[etag]);
      end
      // expected write-back
      for (int w = 0; w < NW; w++) begin
         bit ev;
         ev = fv && m_used[ft][w];
         chk(wb_valid[w] == ev, "R9", "wb_valid", wb_valid[w], ev);
         if (ev) begin
            chk(wb_reg[w*RW +: RW] == m_dest[ft][w], "R9", "wb_reg",
                wb_reg[w*RW +: RW], m_dest[ft][w]);
            chk(wb_data[w*DW +: DW] == fill_data[w*DW +: DW], "R9", "wb_data",
                wb_data[w*DW +: DW], fill_data[w*DW +: DW]);
         end
      end
      // scoreboard query
      for (int k = 0; k < NQ; k++)
         chk(q_empty[k] == m_empty[q_reg[k*RW +: RW]], qtag, "q_empty",
             q_empty[k], m_empty[q_reg[k*RW +: RW]]);
      // model update for the coming edge
      if (exp_mv && rdy) m_reqp[etag] = 0;
      m_hold = exp_mv && !rdy;
      m_hold_idx = IW'(etag);
      if (fv) begin
         for (int w = 0; w < NW; w++) begin
            if (m_used[ft][w]) m_empty[m_dest[ft][w]] = 0;
            m_used[ft][w] = 0;
         end
         m_busy[ft] = 0;
      end
      if (exp_acc) begin
         m_empty[ds] = 1;
         if (hit >= 0) begin
            m_used[hit][wd] = 1; m_dest[hit][wd] = RW'(ds);
         end else begin
            m_busy[fr] = 1; m_reqp[fr] = 1; m_line[fr] = ln;
            m_used[fr][wd] = 1; m_dest[fr][wd] = RW'(ds);
         end
      end
      @(negedge clk);
   endtask

   function automatic int pick_fill();
      int c[$];
      for (int e = 0; e < NE; e++) if (m_busy[e] && !m_reqp[e]) c.push_back(e);
      if (c.size() == 0) return -1;
      return c[$urandom_range(c.size() - 1)];
   endfunction

   initial begin
      void'($urandom(32'd1234));
      for (int e = 0; e < NE; e++) begin
         m_busy[e] = 0; m_reqp[e] = 0; m_line[e] = '0;
         for (int w = 0; w < NW; w++) begin m_used[e][w] = 0; m_dest[e][w] = '0; end
      end
      for (int r = 0; r < NR; r++) m_empty[r] = 0;
      m_hold = 0; m_hold_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset, all registers full
      for (int i = 0; i < 12; i++) cycle(0, '0, 0, 0, 0, 0, 0, "R1");
      // directed corner cases
      cycle(1, 26'h100, 3, 5, 0, 0, 0, "R4");   // allocate entry 0 (R2)
      cycle(1, 26'h100, 4, 6, 0, 0, 0, "R4");   // merge (R3)
      cycle(1, 26'h100, 4, 7, 0, 0, 0, "R4");   // claimed slot (R6)
      cycle(1, 26'h200, 0, 8, 0, 0, 0, "R4");
      cycle(1, 26'h300, 1, 9, 0, 0, 0, "R4");
      cycle(1, 26'h400, 2, 10, 0, 0, 0, "R4");
      cycle(1, 26'h500, 2, 11, 0, 0, 0, "R4");  // all busy (R5)
      cycle(1, 26'h100, 0, 5, 0, 0, 0, "R4");   // dest waiting (R7)
      for (int i = 0; i < 4; i++) cycle(0, '0, 0, 0, 1, 0, 0, "R4"); // drain (R8)
      cycle(1, 26'h100, 1, 12, 0, 1, 0, "R10"); // refill + same line (R11)
      cycle(1, 26'h500, 2, 11, 0, 0, 0, "R10"); // reuse freed entry (R10)
      cycle(0, '0, 0, 0, 1, 0, 0, "R10");
      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         int ft;
         bit fv;
         ft = pick_fill();
         fv = (ft >= 0) && ($urandom_range(99) < 30);
         cycle($urandom_range(99) < 70, LAW'(26'h40 + $urandom_range(5)),
               $urandom_range(NW - 1), $urandom_range(NR - 1),
               $urandom_range(1), fv, fv ? ft : 0, "R4 R10");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule